// File: doc/BRIEF.md
# Register-Write Command Stream Decoder

The decoder reads a linear run of 32-bit command words from memory, starting at a programmed start address and stopping at a programmed end address. It turns those words into writes on a local register bus. The stream is made of five-word packets. The first word of each packet carries four 8-bit register indices. The next four words are the data for those indices. Each index is expanded into an address in one of two 512-byte register banks. One pad register acts as an in-stream no-op. Bank-0 indices that land 0x100 above a real register act as that register's execute alias: the write goes to the base register and is flagged as a batch launch.

Software writes the end address first and then the start address to begin a stream. It may raise the end address while the stream runs to append more packets. Memory reads use a request/response word interface with at most one read in flight. Register writes leave on a valid/ready port that can apply back-pressure. A done flag, an alignment error flag and an idle indication report progress. Idle also takes the drawing-engine busy flag and the pending software-trap flag into account.

Top module: `regstream_decoder`

## Requirements
- R1: Word 0 of a packet holds slot indices with slot k in bits 8k+7:8k (k = 0..3). Data word k+1 is written with slot k's index. Slots leave in order 0, 1, 2, 3, and packets leave in memory order.
- R2: An index with bit 7 clear targets 0x1C00 + 4*index[6:0]. An index with bit 7 set targets 0x2C00 + 4*index[6:0].
- R3: A bank-0 index with bit 6 set (0x40..0x7F) is an execute alias. It is output with regAddr equal to its target minus 0x100 and regExec = 1. Every other index gives regExec = 0.
- R4: Index 0x15 (the pad register, 0x1C54) produces no register write. Its data word is still fetched and consumed.
- R5: Read requests address the packet's words at pointer + 4*w for w = 0..4, in order. The pointer then advances by 20 bytes. A new request is raised only after the previous read's response has arrived.
- R6: While regReady is low, regValid stays high and regAddr, regData and regExec hold. No slot is dropped, duplicated or reordered.
- R7: When the pointer equals the end address, dmaDone is set and no further read is requested. A stream whose start equals its end issues no read and sets dmaDone.
- R8: After reset dmaDone = 1 and alignErr = 0. idle = dmaDone and not engineBusy and not softTrapPending.
- R9: Raising the end address while a stream runs extends that stream without restarting it.
- R10: A start write while a stream is running is ignored. A start write while not running begins a new stream and clears dmaDone and alignErr.
- R11: If fewer than 20 bytes remain before a non-equal end address, the block stops after the last complete packet and sets dmaDone and alignErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startWe | input | 1 | Start-address write strobe |
| startAddr | input | AW | Start byte address |
| endWe | input | 1 | End-address write strobe |
| endAddr | input | AW | End byte address |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Read request accepted |
| memReqAddr | output | AW | Read byte address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data word |
| regValid | output | 1 | Register write valid |
| regReady | input | 1 | Register write accepted |
| regAddr | output | 14 | Register byte address |
| regData | output | 32 | Register write data |
| regExec | output | 1 | Write is an execute-alias batch launch |
| engineBusy | input | 1 | Drawing engine busy |
| softTrapPending | input | 1 | Software trap pending |
| dmaDone | output | 1 | Stream reached its end |
| alignErr | output | 1 | Stream end not packet-aligned |
| idle | output | 1 | Stream done and engine quiet |

## Verification
A word counter that is off by one shows at the ports on the very next transfer. Either the read address breaks the +4 sequence, or a data word is paired with the wrong index. A pointer that steps wrongly shows up at the first request of the following packet. A stale done or error flag shows on dmaDone, alignErr or idle in the cycle after the stream's last check. Every index value from 0x00 to 0xFF goes through the decoder under back-pressure on both sides. Each write is compared in order against an address and data computed arithmetically.

// File: rtl/regdec_pkg.sv
package regdec_pkg;
  localparam int unsigned REG_AW    = 14;
  localparam int unsigned SLOTS     = 4;
  localparam int unsigned PKT_BYTES = (SLOTS + 1) * 4;
  localparam logic [REG_AW-1:0] BANK0_BASE  = 14'h1C00;
  localparam logic [REG_AW-1:0] BANK1_BASE  = 14'h2C00;
  localparam logic [REG_AW-1:0] EXEC_OFFSET = 14'h0100;
  localparam logic [6:0]        PAD_INDEX   = 7'h15;

  typedef enum logic [2:0] {ST_IDLE, ST_CHECK, ST_REQ, ST_WAIT, ST_EMIT} seqState_t;

  typedef struct packed {
    logic loadStart;
    logic latchHdr;
    logic latchData;
    logic nextPkt;
  } dpStrobe_t;
endpackage

// File: rtl/regdec_datapath.sv
module regdec_datapath
  import regdec_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         ctl,
  input  logic [2:0]        wordSel,
  input  logic [AW-1:0]     startAddr,
  input  logic              endWe,
  input  logic [AW-1:0]     endAddr,
  input  logic [31:0]       memRspData,
  output logic [AW-1:0]     memReqAddr,
  output logic              canFetch,
  output logic              atEnd,
  output logic              slotPad,
  output logic [REG_AW-1:0] regAddr,
  output logic [31:0]       regData,
  output logic              regExec
);
  logic [AW-1:0] ptrQ, endQ;
  logic [31:0]   hdrQ, dataQ;
  logic [7:0]    idxArr [SLOTS];
  logic [1:0]    slotIdx;
  logic [7:0]    idx;
  logic [REG_AW-1:0] target;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0; endQ <= '0; hdrQ <= '0; dataQ <= '0;
    end else begin
      if (endWe)             endQ  <= endAddr;
      if (ctl.loadStart)     ptrQ  <= startAddr;
      else if (ctl.nextPkt)  ptrQ  <= ptrQ + AW'(PKT_BYTES);
      if (ctl.latchHdr)      hdrQ  <= memRspData;
      if (ctl.latchData)     dataQ <= memRspData;
    end
  end

  assign memReqAddr = ptrQ + AW'({wordSel, 2'b00});
  assign canFetch   = ({1'b0, ptrQ} + (AW+1)'(PKT_BYTES)) <= {1'b0, endQ};
  assign atEnd      = (ptrQ == endQ);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign idxArr[g] = hdrQ[8*g +: 8];
  end

  assign slotIdx = 2'(wordSel - 3'd1);
  assign idx     = idxArr[slotIdx];
  assign target  = (idx[7] ? BANK1_BASE : BANK0_BASE) + {5'd0, idx[6:0], 2'b00};
  assign regExec = !idx[7] && idx[6];
  assign regAddr = regExec ? target - EXEC_OFFSET : target;
  assign slotPad = !idx[7] && (idx[6:0] == PAD_INDEX);
  assign regData = dataQ;

  p_pkt_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.nextPkt |=> ptrQ == $past(ptrQ) + AW'(PKT_BYTES));
endmodule

// File: rtl/regdec_ctrl.sv
module regdec_ctrl
  import regdec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startWe,
  input  logic       canFetch,
  input  logic       atEnd,
  input  logic       slotPad,
  input  logic       memReqReady,
  input  logic       memRspValid,
  input  logic       regReady,
  output dpStrobe_t  ctl,
  output logic [2:0] wordSel,
  output logic       memReqValid,
  output logic       regValid,
  output logic       dmaDone,
  output logic       alignErr
);
  seqState_t stQ, stNext;
  logic [2:0] wcQ, wcNext;
  logic doneQ, errQ;

  always_comb begin
    ctl    = '0;
    stNext = stQ;
    wcNext = wcQ;
    unique case (stQ)
      ST_IDLE:  if (startWe) begin ctl.loadStart = 1'b1; wcNext = '0; stNext = ST_CHECK; end
      ST_CHECK: stNext = canFetch ? ST_REQ : ST_IDLE;
      ST_REQ:   if (memReqReady) stNext = ST_WAIT;
      ST_WAIT:
        if (memRspValid) begin
          if (wcQ == 3'd0) begin
            ctl.latchHdr = 1'b1; wcNext = 3'd1; stNext = ST_REQ;
          end else begin
            ctl.latchData = 1'b1;
            if (!slotPad) stNext = ST_EMIT;
            else if (wcQ == 3'(SLOTS)) begin ctl.nextPkt = 1'b1; wcNext = '0; stNext = ST_CHECK; end
            else begin wcNext = wcQ + 3'd1; stNext = ST_REQ; end
          end
        end
      ST_EMIT:
        if (regReady) begin
          if (wcQ == 3'(SLOTS)) begin ctl.nextPkt = 1'b1; wcNext = '0; stNext = ST_CHECK; end
          else begin wcNext = wcQ + 3'd1; stNext = ST_REQ; end
        end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ <= ST_IDLE; wcQ <= '0; doneQ <= 1'b1; errQ <= 1'b0;
    end else begin
      stQ <= stNext;
      wcQ <= wcNext;
      if (ctl.loadStart) begin
        doneQ <= 1'b0; errQ <= 1'b0;
      end else if (stQ == ST_CHECK && !canFetch) begin
        doneQ <= 1'b1; errQ <= !atEnd;
      end
    end
  end

  assign wordSel     = wcQ;
  assign memReqValid = (stQ == ST_REQ);
  assign regValid    = (stQ == ST_EMIT);
  assign dmaDone     = doneQ;
  assign alignErr    = errQ;

  p_one_outstanding_r5: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqReady |=> !memReqValid);
  p_no_fetch_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !doneQ);
  p_err_implies_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> doneQ);
endmodule

// File: rtl/regstream_decoder.sv
module regstream_decoder
  import regdec_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startWe,
  input  logic [AW-1:0]     startAddr,
  input  logic              endWe,
  input  logic [AW-1:0]     endAddr,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [AW-1:0]     memReqAddr,
  input  logic              memRspValid,
  input  logic [31:0]       memRspData,
  output logic              regValid,
  input  logic              regReady,
  output logic [REG_AW-1:0] regAddr,
  output logic [31:0]       regData,
  output logic              regExec,
  input  logic              engineBusy,
  input  logic              softTrapPending,
  output logic              dmaDone,
  output logic              alignErr,
  output logic              idle
);
  dpStrobe_t  ctl;
  logic [2:0] wordSel;
  logic       canFetch, atEnd, slotPad;

  regdec_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .startWe(startWe), .canFetch(canFetch), .atEnd(atEnd),
    .slotPad(slotPad), .memReqReady(memReqReady), .memRspValid(memRspValid),
    .regReady(regReady), .ctl(ctl), .wordSel(wordSel), .memReqValid(memReqValid),
    .regValid(regValid), .dmaDone(dmaDone), .alignErr(alignErr)
  );

  regdec_datapath #(.AW(AW)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wordSel(wordSel), .startAddr(startAddr),
    .endWe(endWe), .endAddr(endAddr), .memRspData(memRspData), .memReqAddr(memReqAddr),
    .canFetch(canFetch), .atEnd(atEnd), .slotPad(slotPad), .regAddr(regAddr),
    .regData(regData), .regExec(regExec)
  );

  assign idle = dmaDone && !engineBusy && !softTrapPending;

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    regValid && !regReady |=> regValid && $stable(regAddr) && $stable(regData) && $stable(regExec));
  p_no_pad_r4: assert property (@(posedge clk) disable iff (!rstN)
    regValid |-> !(regAddr == 14'h1C54 && !regExec));
  p_bank_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    regValid |-> (regAddr >= 14'h1C00 && regAddr < 14'h1D00) ||
                 (regAddr >= 14'h2C00 && regAddr <= 14'h2DFC));
endmodule

// File: tb/test_regstream_decoder.sv
module test_regstream_decoder;
  localparam int AW = 32;
  localparam logic [31:0] MBASE = 32'h0001_0000;
  localparam int NPKT = 64;

  logic clk = 0, rstN = 0;
  logic startWe = 0, endWe = 0;
  logic [AW-1:0] startAddr = '0, endAddr = '0;
  logic memReqValid, memReqReady = 0, memRspValid = 0;
  logic [AW-1:0] memReqAddr;
  logic [31:0] memRspData = '0;
  logic regValid, regReady = 0, regExec;
  logic [13:0] regAddr;
  logic [31:0] regData;
  logic engineBusy = 0, softTrapPending = 0;
  logic dmaDone, alignErr, idle;

  always #2.5 clk = ~clk;

  regstream_decoder #(.AW(AW)) i_regstream_decoder (
    .clk(clk), .rstN(rstN), .startWe(startWe), .startAddr(startAddr), .endWe(endWe),
    .endAddr(endAddr), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .regValid(regValid), .regReady(regReady), .regAddr(regAddr), .regData(regData),
    .regExec(regExec), .engineBusy(engineBusy), .softTrapPending(softTrapPending),
    .dmaDone(dmaDone), .alignErr(alignErr), .idle(idle)
  );

  int nChecks = 0, nFail = 0;
  logic [31:0] mem [NPKT*5];
  logic [13:0] expAddr [$];
  logic [31:0] expData [$];
  logic        expExec [$];
  int gotCnt = 0, reqCnt = 0, cyc = 0;
  logic [31:0] nextReqAddr = '0;
  logic [31:0] pendAddr = '0;
  bit outstanding = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic addExp(input int p0, input int p1);
    for (int p = p0; p < p1; p++)
      for (int k = 0; k < 4; k++) begin
        logic [7:0] ix;
        logic [13:0] tgt;
        logic ex;
        ix  = 8'(4*p + k);
        if (ix == 8'h15) continue;
        tgt = (ix[7] ? 14'h2C00 : 14'h1C00) + 14'(ix[6:0]) * 14'd4;
        ex  = !ix[7] && ix[6];
        expAddr.push_back(ex ? tgt - 14'h0100 : tgt);
        expData.push_back(mem[5*p + 1 + k]);
        expExec.push_back(ex);
      end
  endtask

  // bus models and write monitor, all at the falling edge
  always @(negedge clk) begin
    bit rr, mr;
    cyc++;
    rr = (cyc % 3) != 1;
    mr = (cyc % 4) != 2;
    // R6 R1 R2 R3: compare each accepted write in order
    if (regValid && rr) begin
      gotCnt++;
      if (expAddr.size() == 0) chk(0, "R6 unexpected write", 64'(regAddr), 64'h0);
      else begin
        logic [13:0] ea; logic [31:0] ed; logic ee;
        ea = expAddr.pop_front(); ed = expData.pop_front(); ee = expExec.pop_front();
        chk(regAddr == ea, "R2 regAddr", 64'(regAddr), 64'(ea));
        chk(regData == ed, "R1 regData", 64'(regData), 64'(ed));
        chk(regExec == ee, "R3 regExec", 64'(regExec), 64'(ee));
      end
    end
    regReady = rr;
    // memory model
    if (outstanding) begin
      if (memReqValid) chk(0, "R5 request while read in flight", 64'(memReqAddr), 64'h0);
      memRspValid = 1;
      memRspData  = mem[((pendAddr - MBASE) >> 2) % (NPKT*5)];
      outstanding = 0;
    end else begin
      memRspValid = 0;
      memRspData  = 32'hDEAD_BEEF;
      if (memReqValid && mr) begin
        reqCnt++;
        if (memReqAddr != nextReqAddr) chk(0, "R5 read address", 64'(memReqAddr), 64'(nextReqAddr));
        nextReqAddr = memReqAddr + 4;
        pendAddr    = memReqAddr;
        outstanding = 1;
      end
    end
    memReqReady = mr;
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  task automatic writeEnd(input logic [31:0] a);
    @(negedge clk); endWe = 1; endAddr = a;
    @(negedge clk); endWe = 0;
  endtask

  task automatic writeStart(input logic [31:0] a);
    @(negedge clk); startWe = 1; startAddr = a;
    @(negedge clk); startWe = 0;
  endtask

  task automatic waitDone();
    while (!dmaDone) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int p = 0; p < NPKT; p++) begin
      mem[5*p] = {8'(4*p+3), 8'(4*p+2), 8'(4*p+1), 8'(4*p)};
      for (int k = 1; k <= 4; k++) mem[5*p+k] = 32'hD000_0000 | 32'((5*p+k) * 7919);
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); #1;
    // R8 reset state
    chk(dmaDone == 1, "R8 reset dmaDone", 64'(dmaDone), 64'h1);
    chk(alignErr == 0, "R8 reset alignErr", 64'(alignErr), 64'h0);
    chk(idle == 1, "R8 reset idle", 64'(idle), 64'h1);
    chk(!memReqValid && !regValid, "R7 no activity after reset", 64'({memReqValid, regValid}), 64'h0);

    // full sweep of all indices, end raised mid-stream (R1..R6, R9)
    addExp(0, NPKT);
    nextReqAddr = MBASE;
    writeEnd(MBASE + 20*8);
    writeStart(MBASE);
    #1 chk(dmaDone == 0 && idle == 0, "R10 start clears done", 64'({dmaDone, idle}), 64'h0);
    while (gotCnt < 10) @(negedge clk);
    writeEnd(MBASE + 20*NPKT);
    waitDone();
    chk(expAddr.size() == 0, "R9 all writes after extension", 64'(expAddr.size()), 64'h0);
    chk(reqCnt == 5*NPKT, "R4 R5 every word fetched", 64'(reqCnt), 64'(5*NPKT));
    chk(alignErr == 0, "R7 aligned end no error", 64'(alignErr), 64'h0);
    chk(memReqAddr == MBASE + 20*NPKT, "R7 pointer at end", 64'(memReqAddr), 64'(MBASE + 20*NPKT));

    // R8 idle combinations
    engineBusy = 1; #1 chk(idle == 0, "R8 idle with busy engine", 64'(idle), 64'h0);
    engineBusy = 0; softTrapPending = 1; #1 chk(idle == 0, "R8 idle with trap", 64'(idle), 64'h0);
    softTrapPending = 0; #1 chk(idle == 1, "R8 idle quiet", 64'(idle), 64'h1);

    // R10 start while running is ignored
    reqCnt = 0; gotCnt = 0;
    addExp(0, 4);
    nextReqAddr = MBASE;
    writeEnd(MBASE + 80);
    writeStart(MBASE);
    while (gotCnt < 3) @(negedge clk);
    writeStart(MBASE + 200);
    waitDone();
    chk(expAddr.size() == 0 && gotCnt == 16, "R10 running start ignored", 64'(gotCnt), 64'd16);
    chk(reqCnt == 20, "R10 read count", 64'(reqCnt), 64'd20);

    // R11 misaligned end
    reqCnt = 0; gotCnt = 0;
    addExp(0, 2);
    nextReqAddr = MBASE;
    writeEnd(MBASE + 48);
    writeStart(MBASE);
    waitDone();
    chk(alignErr == 1, "R11 alignErr set", 64'(alignErr), 64'h1);
    chk(gotCnt == 8 && expAddr.size() == 0, "R11 complete packets only", 64'(gotCnt), 64'd8);
    chk(reqCnt == 10, "R11 reads stop at last packet", 64'(reqCnt), 64'd10);

    // R7 start equals end, also clears error (R10)
    reqCnt = 0; gotCnt = 0;
    writeEnd(MBASE + 20);
    writeStart(MBASE + 20);
    waitDone();
    chk(reqCnt == 0 && gotCnt == 0, "R7 empty stream", 64'(reqCnt + gotCnt), 64'h0);
    chk(alignErr == 0, "R10 error cleared by new start", 64'(alignErr), 64'h0);
    chk(dmaDone == 1 && idle == 1, "R7 empty stream done", 64'({dmaDone, idle}), 64'h3);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule